// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the system side of an asynchronous parallel NOR flash bus. It takes one request at a time over a valid/ready handshake. A request asks for one of three things: program one byte, erase a set of sectors, or erase the whole chip. The block then produces the command write sequence the flash expects. It times every write-enable pulse in whole clock cycles. Once the last command write is on the bus, it reads status repeatedly at a legal address until bit 7 of the data bus shows that the operation has finished.

The result comes back as a one-cycle `done` pulse, with `error` raised in the same cycle when the request was rejected or timed out. A program request first reads the target byte. If the new value would need any bit to go from 0 to 1, the request is refused before any write reaches the bus. Sector erase requests carry a bit mask with one bit per sector. The follow-on sector writes are issued back to back, at a fixed period in clock cycles, so they all land inside the device's acceptance window.

Top module: `flash_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. Requests presented while an operation runs are not taken, and they cause no bus activity after `done`.
- R2: A program request (`req_op` = 0) first reads the target address. It then issues four writes as address/data pairs: 555h/AAh, 2AAh/55h, 555h/A0h, and finally the target address with the request byte.
- R3: If the byte read at the target has a 0 in any bit where the request byte has a 1, the request ends with `done` and `error` and issues no write.
- R4: A chip erase (`req_op` = 2) issues exactly six writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h.
- R5: A sector erase (`req_op` = 1) issues the first five chip-erase writes. It then issues one write of 30h for each set bit of `req_sectors`. These go in ascending bit order, each to the sector base address (bit index placed in the top `log2(SECT_N)` address bits, the low bits zero).
- R6: Successive write strobes end exactly `WE_LOW_CYC + RECOV_CYC + 4` cycles apart. Every write strobe after the first in an operation ends less than `ERASE_WINDOW_CYC` cycles after the previous one.
- R7: Each write holds `fl_we_n` low for exactly `WE_LOW_CYC` cycles, with `fl_ce_n` low, `fl_dq_oe` high and `fl_oe_n` high. The data bus is never driven while `fl_oe_n` is low.
- R8: After a program, status reads are made at the target address. The operation completes without error on the first read whose bit 7 equals bit 7 of the request byte.
- R9: After an erase, status reads are made at the base of the lowest selected sector (address 0 for chip erase). The operation completes without error on the first read with bit 7 high.
- R10: If `POLL_MAX` status reads pass without completion, the request ends with `done` and `error` and the sequencer is ready again. Completion on read number `POLL_MAX` is still a success.
- R11: A sector erase with an all-zero mask, or `req_op` = 3, ends with `done` and `error` on the cycle after acceptance, with no bus cycle.
- R12: `done` is a single-cycle pulse, and `error` is never high without `done`. After reset, `req_ready` is high and `done`, `error`, `fl_ce_n`, `fl_oe_n`, `fl_we_n` are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | ADDR_W | Byte address for program |
| req_data | input | 8 | Byte value for program |
| req_sectors | input | SECT_N | Sector selection mask for sector erase |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for fl_dq_out |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
A behavioural flash model on the bench keeps a small sparse memory and decodes the command writes. Its busy latency, counted in status reads, is set per request. Directed cases separate the three operations. They include a program whose byte has bit 7 set against one with bit 7 clear, which tells a true DQ7 comparison apart from a plain "bit 7 high" test. A program that would raise a bit shows that the pre-read guard stops the bus. Latencies of `POLL_MAX-1` and `POLL_MAX` pin down the exact timeout boundary. Sector masks with a single low bit, three scattered bits and all bits set check the ordering, the base addresses and the strobe period. Seeded random requests on top of these compare the full write log, the poll address and the resulting memory against values computed by bench functions.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CHECK,
    PH_CMD,
    PH_SECT,
    PH_POLL
  } phase_e;

  typedef enum logic [2:0] {
    BC_IDLE,
    BC_SETUP,
    BC_LOW,
    BC_RECOV,
    BC_READ
  } bus_st_e;

  localparam logic [11:0] KEY_ADDR_A = 12'h555;
  localparam logic [11:0] KEY_ADDR_B = 12'h2AA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  CODE_PROG  = 8'hA0;
  localparam logic [7:0]  CODE_ERASE = 8'h80;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;
  localparam logic [7:0]  CODE_SECT  = 8'h30;

endpackage

// File: rtl/flash_low_pick.sv
module flash_low_pick #(
  parameter int N = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot,
  output logic          any
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
    onehot = mask & (~mask + N'(1));
    any    = |mask;
  end

endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int WE_LOW_CYC = 4,
  parameter int RECOV_CYC  = 4,
  parameter int READ_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              done,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  localparam int MAX_AB = (WE_LOW_CYC > RECOV_CYC) ? WE_LOW_CYC : RECOV_CYC;
  localparam int MAX_C  = (MAX_AB > READ_CYC) ? MAX_AB : READ_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  bus_st_e          st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= BC_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      rdata     <= '0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      fl_we_n   <= 1'b1;
    end else begin
      done <= 1'b0;
      case (st)
        BC_IDLE: if (start) begin
          fl_addr   <= addr;
          fl_dq_out <= wdata;
          fl_ce_n   <= 1'b0;
          if (is_read) begin
            fl_oe_n <= 1'b0;
            cnt     <= CNT_W'(READ_CYC - 1);
            st      <= BC_READ;
          end else begin
            fl_dq_oe <= 1'b1;
            st       <= BC_SETUP;
          end
        end
        BC_SETUP: begin
          fl_we_n <= 1'b0;
          cnt     <= CNT_W'(WE_LOW_CYC - 1);
          st      <= BC_LOW;
        end
        BC_LOW: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b1;
            cnt     <= CNT_W'(RECOV_CYC - 1);
            st      <= BC_RECOV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BC_RECOV: begin
          if (cnt == '0) begin
            fl_dq_oe <= 1'b0;
            fl_ce_n  <= 1'b1;
            done     <= 1'b1;
            st       <= BC_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BC_READ: begin
          if (cnt == '0) begin
            rdata   <= fl_dq_in;
            fl_oe_n <= 1'b1;
            fl_ce_n <= 1'b1;
            done    <= 1'b1;
            st      <= BC_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= BC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int SECT_N   = 32,
  parameter int POLL_MAX = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic [SECT_N-1:0] req_sectors,
  output logic              done,
  output logic              error,
  output logic              bus_start,
  output logic              bus_read,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_done,
  input  logic [7:0]        bus_rdata
);

  localparam int SECT_W = (SECT_N > 1) ? $clog2(SECT_N) : 1;
  localparam int OFS_W  = ADDR_W - SECT_W;
  localparam int PC_W   = $clog2(POLL_MAX + 1);

  phase_e            phase;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q, poll_addr;
  logic [7:0]        data_q;
  logic [SECT_N-1:0] pend, pick_mask, pick_oh;
  logic [SECT_W-1:0] pick_idx;
  logic              pick_any, wt;
  logic [2:0]        step, last_step;
  logic [PC_W-1:0]   poll_cnt;
  logic [ADDR_W-1:0] sect_base, cmd_addr;
  logic [7:0]        cmd_data;
  logic              poll_ok;

  assign pick_mask = (phase == PH_IDLE) ? req_sectors : pend;

  flash_low_pick #(.N(SECT_N)) u_pick (
    .mask(pick_mask), .idx(pick_idx), .onehot(pick_oh), .any(pick_any)
  );

  assign sect_base = ADDR_W'(pick_idx) << OFS_W;
  assign req_ready = (phase == PH_IDLE);
  assign poll_ok   = (op_q == OP_PROG) ? (bus_rdata[7] == data_q[7]) : bus_rdata[7];

  always_comb begin
    cmd_addr  = ADDR_W'(KEY_ADDR_A);
    cmd_data  = KEY_DATA_A;
    last_step = (op_q == OP_PROG) ? 3'd3 : (op_q == OP_SECT) ? 3'd4 : 3'd5;
    case (step)
      3'd1: begin cmd_addr = ADDR_W'(KEY_ADDR_B); cmd_data = KEY_DATA_B; end
      3'd2: cmd_data = (op_q == OP_PROG) ? CODE_PROG : CODE_ERASE;
      3'd3: if (op_q == OP_PROG) begin cmd_addr = addr_q; cmd_data = data_q; end
      3'd4: begin cmd_addr = ADDR_W'(KEY_ADDR_B); cmd_data = KEY_DATA_B; end
      3'd5: cmd_data = CODE_CHIP;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      op_q      <= OP_PROG;
      addr_q    <= '0;
      data_q    <= '0;
      poll_addr <= '0;
      pend      <= '0;
      step      <= '0;
      poll_cnt  <= '0;
      wt        <= 1'b0;
      bus_start <= 1'b0;
      bus_read  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      bus_start <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      if (phase == PH_IDLE) begin
        if (req_valid) begin
          op_q     <= op_e'(req_op);
          addr_q   <= req_addr;
          data_q   <= req_data;
          pend     <= req_sectors;
          step     <= '0;
          poll_cnt <= '0;
          wt       <= 1'b0;
          case (op_e'(req_op))
            OP_PROG: begin phase <= PH_CHECK; poll_addr <= req_addr; end
            OP_CHIP: begin phase <= PH_CMD; poll_addr <= '0; end
            OP_SECT: begin
              if (pick_any) begin
                phase     <= PH_CMD;
                poll_addr <= sect_base;
              end else begin
                done  <= 1'b1;
                error <= 1'b1;
              end
            end
            default: begin done <= 1'b1; error <= 1'b1; end
          endcase
        end
      end else if (!wt) begin
        wt        <= 1'b1;
        bus_start <= 1'b1;
        bus_read  <= (phase == PH_CHECK) || (phase == PH_POLL);
        case (phase)
          PH_CHECK: bus_addr <= addr_q;
          PH_CMD:   begin bus_addr <= cmd_addr; bus_wdata <= cmd_data; end
          PH_SECT:  begin bus_addr <= sect_base; bus_wdata <= CODE_SECT; end
          default:  bus_addr <= poll_addr;
        endcase
      end else if (bus_done) begin
        wt <= 1'b0;
        case (phase)
          PH_CHECK: begin
            if ((~bus_rdata & data_q) != 8'h00) begin
              phase <= PH_IDLE; done <= 1'b1; error <= 1'b1;
            end else begin
              phase <= PH_CMD;
            end
          end
          PH_CMD: begin
            if (step == last_step) phase <= (op_q == OP_SECT) ? PH_SECT : PH_POLL;
            else step <= step + 3'd1;
          end
          PH_SECT: begin
            pend <= pend & ~pick_oh;
            if ((pend & ~pick_oh) == '0) phase <= PH_POLL;
          end
          default: begin
            if (poll_ok) begin
              phase <= PH_IDLE; done <= 1'b1;
            end else if (poll_cnt == PC_W'(POLL_MAX - 1)) begin
              phase <= PH_IDLE; done <= 1'b1; error <= 1'b1;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int ADDR_W           = 21,
  parameter int SECT_N           = 32,
  parameter int WE_LOW_CYC       = 4,
  parameter int RECOV_CYC        = 4,
  parameter int READ_CYC         = 3,
  parameter int POLL_MAX         = 4096,
  parameter int ERASE_WINDOW_CYC = 12500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic [SECT_N-1:0] req_sectors,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  logic              bus_start, bus_read, bus_done;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata, bus_rdata;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .SECT_N(SECT_N), .POLL_MAX(POLL_MAX)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_sectors(req_sectors),
    .done(done), .error(error),
    .bus_start(bus_start), .bus_read(bus_read), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata)
  );

  flash_bus_cycle #(
    .ADDR_W(ADDR_W), .WE_LOW_CYC(WE_LOW_CYC), .RECOV_CYC(RECOV_CYC), .READ_CYC(READ_CYC)
  ) u_bus (
    .clk(clk), .rst(rst),
    .start(bus_start), .is_read(bus_read), .addr(bus_addr), .wdata(bus_wdata),
    .done(bus_done), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int WE_LOW_CYC       = 4,
  parameter int ERASE_WINDOW_CYC = 12500
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic done,
  input logic error,
  input logic fl_ce_n,
  input logic fl_oe_n,
  input logic fl_we_n,
  input logic fl_dq_oe
);

  logic [15:0] low_cnt;
  logic [31:0] gap_cnt;
  logic        seen_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      gap_cnt   <= '0;
      seen_rise <= 1'b0;
    end else begin
      low_cnt <= fl_we_n ? 16'd0 : ((low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1);
      if (fl_we_n && (low_cnt != 16'd0)) begin
        gap_cnt   <= 32'd1;
        seen_rise <= 1'b1;
      end else if (gap_cnt != 32'hFFFF_FFFF) begin
        gap_cnt <= gap_cnt + 32'd1;
      end
      if (done) seen_rise <= 1'b0;
    end
  end

  assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (rst)
    !fl_ce_n |-> !req_ready);

  assert_we_frame_R7: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> (!fl_ce_n && fl_dq_oe && fl_oe_n));

  assert_no_clash_R7: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);

  assert_we_width_R7: assert property (@(posedge clk) disable iff (rst)
    (fl_we_n && (low_cnt != 16'd0)) |-> (low_cnt == 16'(WE_LOW_CYC)));

  assert_window_R6: assert property (@(posedge clk) disable iff (rst)
    (fl_we_n && (low_cnt != 16'd0) && seen_rise) |-> (gap_cnt < 32'(ERASE_WINDOW_CYC)));

  assert_err_with_done_R12: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind flash_seq flash_seq_chk #(
  .WE_LOW_CYC(WE_LOW_CYC), .ERASE_WINDOW_CYC(ERASE_WINDOW_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .done(done), .error(error),
  .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_dq_oe(fl_dq_oe)
);

// File: tb/test_flash_seq.sv
`timescale 1ns/1ps
module test_flash_seq;
  localparam int AW = 21, SN = 32, WEL = 4, RCV = 4, RDC = 3, PM = 64, WIN = 12500;
  localparam int PERIOD_CYC = WEL + RCV + 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready, done, error;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [7:0] req_data = 0;
  logic [SN-1:0] req_sectors = 0;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_out, fl_dq_in;
  logic fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flash_seq #(.POLL_MAX(PM)) i_flash_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_sectors(req_sectors),
    .done(done), .error(error), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n)
  );

  // ---------------- flash model ----------------
  logic [7:0] mem [0:255];
  logic [7:0] exp_mem [0:255];
  logic busy = 0;
  int busy_kind = 0, busy_cnt = 0, lat = 0;
  logic [7:0] prog_data;
  logic [AW-1:0] prog_addr;
  logic [31:0] erase_set = 0;
  logic [AW-1:0] wr_a [0:63];
  logic [7:0] wr_d [0:63];
  int wr_n = 0, rd_n = 0;
  logic [AW-1:0] last_rd;
  realtime t_fall = 0, t_rise = 0;
  int min_low, max_low, min_gap, max_gap;

  function automatic int midx(logic [AW-1:0] a);
    return {a[20:16], a[2:0]};
  endfunction

  assign fl_dq_in = busy ? ((busy_kind == 1) ? {~prog_data[7], 7'h00} : 8'h00)
                         : mem[midx(fl_addr)];

  task automatic finish_op();
    if (busy_kind == 1) mem[midx(prog_addr)] = mem[midx(prog_addr)] & prog_data;
    else if (busy_kind == 2) begin
      for (int s = 0; s < 32; s++)
        if (erase_set[s]) for (int o = 0; o < 8; o++) mem[s*8+o] = 8'hFF;
      erase_set = 0;
    end else if (busy_kind == 3) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    end
    busy = 0;
  endtask

  task automatic begin_op(int k);
    busy_kind = k;
    if (lat == 0) finish_op();
    else begin busy = 1; busy_cnt = lat; end
  endtask

  always @(negedge fl_we_n) t_fall = $realtime;

  always @(posedge fl_we_n) begin
    int lw, gp;
    lw = int'(($realtime - t_fall) / 4.0);
    if (lw < min_low) min_low = lw;
    if (lw > max_low) max_low = lw;
    if (wr_n > 0) begin
      gp = int'(($realtime - t_rise) / 4.0);
      if (gp < min_gap) min_gap = gp;
      if (gp > max_gap) max_gap = gp;
    end
    t_rise = $realtime;
    if (wr_n < 64) begin wr_a[wr_n] = fl_addr; wr_d[wr_n] = fl_dq_out; end
    if (wr_n == 3 && wr_d[2] == 8'hA0) begin
      prog_addr = fl_addr; prog_data = fl_dq_out; begin_op(1);
    end else if (wr_n == 5 && fl_dq_out == 8'h10) begin
      begin_op(3);
    end else if (wr_n >= 5 && fl_dq_out == 8'h30) begin
      erase_set[fl_addr[20:16]] = 1'b1; begin_op(2);
    end
    wr_n++;
  end

  always @(posedge fl_oe_n) begin
    rd_n++;
    last_rd = fl_addr;
    if (busy) begin
      busy_cnt--;
      if (busy_cnt == 0) finish_op();
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [28:0] exp_wr(int op, int i, logic [AW-1:0] a, logic [7:0] d,
                                         logic [31:0] m);
    int n, c;
    case (i)
      0: return {21'h555, 8'hAA};
      1: return {21'h2AA, 8'h55};
      2: return {21'h555, (op == 0) ? 8'hA0 : 8'h80};
      3: return (op == 0) ? {a, d} : {21'h555, 8'hAA};
      4: return {21'h2AA, 8'h55};
      default: begin
        if (op == 2) return {21'h555, 8'h10};
        n = i - 5; c = 0;
        for (int s = 0; s < 32; s++) begin
          if (m[s]) begin
            if (c == n) return {AW'(s) << 16, 8'h30};
            c++;
          end
        end
        return '0;
      end
    endcase
  endfunction

  function automatic int lowest(logic [31:0] m);
    for (int s = 0; s < 32; s++) if (m[s]) return s;
    return 0;
  endfunction

  // Runs one request and checks it against the model and expected values.
  task automatic run_req(int op, logic [AW-1:0] a, logic [7:0] d, logic [31:0] m,
                         int latency, bit stray);
    bit exp_err, rejected, timeout, got_done;
    int exp_n, cyc;
    logic [28:0] ew;
    rejected = (op == 3) || (op == 1 && m == 0) || (op == 0 && ((~mem[midx(a)] & d) != 0));
    timeout  = !rejected && (latency >= PM);
    exp_err  = rejected || timeout;
    exp_n    = rejected ? 0 : (op == 0) ? 4 : (op == 2) ? 6 : 5 + $countones(m);
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    if (!exp_err) begin
      if (op == 0) exp_mem[midx(a)] = mem[midx(a)] & d;
      else if (op == 2) for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
      else for (int s = 0; s < 32; s++) if (m[s]) for (int o = 0; o < 8; o++) exp_mem[s*8+o] = 8'hFF;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    wr_n = 0; rd_n = 0; lat = latency;
    min_low = 1 << 20; max_low = 0; min_gap = 1 << 20; max_gap = 0;
    req_valid = 1; req_op = op[1:0]; req_addr = a; req_data = d; req_sectors = m;
    @(negedge clk);
    req_valid = 0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      chk(!req_ready, "R1", "ready while busy", req_ready, 0);
      if (stray) begin
        req_valid = (cyc < 5); req_op = 2'd2;
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 0;
    got_done = done;
    chk(got_done, "R12", "done seen", got_done, 1);
    chk(error == exp_err, rejected ? ((op == 0) ? "R3" : "R11") : timeout ? "R10"
        : (op == 0) ? "R8" : "R9", "error flag", error, exp_err);
    if (rejected && op != 0) chk(cyc == 0, "R11", "cycles to done", cyc, 0);
    if (rejected) chk(rd_n == ((op == 0) ? 1 : 0), "R11", "reads before reject", rd_n,
                      (op == 0) ? 1 : 0);
    @(negedge clk);
    chk(!done && !error, "R12", "done is one pulse", done, 0);
    chk(req_ready, "R10", "ready after end", req_ready, 1);
    chk(wr_n == exp_n, (op == 0) ? "R2" : (op == 2) ? "R4" : "R5", "write count", wr_n, exp_n);
    for (int i = 0; i < exp_n && i < wr_n && i < 64; i++) begin
      ew = exp_wr(op, i, a, d, m);
      chk({wr_a[i], wr_d[i]} == ew, (op == 0) ? "R2" : (op == 2) ? "R4" : "R5",
          $sformatf("write %0d addr/data", i), {wr_a[i], wr_d[i]}, ew);
    end
    if (wr_n > 0) begin
      chk(min_low == WEL && max_low == WEL, "R7", "we low cycles", max_low, WEL);
    end
    if (wr_n > 1) begin
      chk(min_gap == PERIOD_CYC && max_gap == PERIOD_CYC, "R6", "strobe period",
          max_gap, PERIOD_CYC);
      chk(max_gap < WIN, "R6", "within window", max_gap, WIN);
    end
    if (!exp_err) begin
      if (op == 0) chk(last_rd == a, "R8", "poll address", last_rd, a);
      else if (op == 2) chk(last_rd == 0, "R9", "poll address", last_rd, 0);
      else chk(last_rd == (AW'(lowest(m)) << 16), "R9", "poll address", last_rd,
               AW'(lowest(m)) << 16);
      chk(rd_n == ((op == 0) ? 1 : 0) + latency + 1, (op == 0) ? "R8" : "R9",
          "status reads", rd_n, ((op == 0) ? 1 : 0) + latency + 1);
    end
    if (timeout) begin
      chk(rd_n == ((op == 0) ? 1 : 0) + PM, "R10", "reads before timeout", rd_n,
          ((op == 0) ? 1 : 0) + PM);
      busy = 0; erase_set = 0;
    end else begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
      chk(bad == 0, (op == 0) ? "R2" : (op == 2) ? "R4" : "R5", "memory image mismatches",
          bad, 0);
    end
  endtask

  // ---------------- watchdog ----------------
  bit finished = 0;
  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    int seed, op, s, o, l;
    logic [7:0] d, cur;
    logic [31:0] m;
    logic [AW-1:0] a;
    seed = 32'h5EED_F1A5;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready, "R12", "reset ready", req_ready, 1);
    chk(!done && !error, "R12", "reset done/error", {done, error}, 0);
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R12", "reset strobes", {fl_ce_n, fl_oe_n, fl_we_n}, 7);

    run_req(2, 0, 0, 0, 5, 0);                         // R4 chip erase
    run_req(0, {5'd3, 13'd0, 3'd2}, 8'h5A, 0, 3, 0);   // R2 R8 bit7 clear
    run_req(0, {5'd3, 13'd0, 3'd2}, 8'h7A, 0, 3, 0);   // R3 raise of bit 5
    run_req(0, {5'd7, 13'd0, 3'd5}, 8'hC3, 0, 2, 0);   // R8 bit7 set
    run_req(0, {5'd9, 13'd0, 3'd1}, 8'h3C, 0, 0, 0);   // R8 done on first poll
    run_req(1, 0, 0, 32'h8000_0208, 4, 0);             // R5 three sectors
    run_req(1, 0, 0, 32'h0, 4, 0);                     // R11 empty mask
    run_req(3, 0, 0, 0, 4, 0);                         // R11 reserved op
    run_req(0, {5'd1, 13'd0, 3'd0}, 8'h11, 0, PM - 1, 0); // R10 boundary success
    run_req(0, {5'd1, 13'd0, 3'd3}, 8'h22, 0, PM, 0);     // R10 timeout
    run_req(1, 0, 0, 32'h0000_0001, 1, 0);             // R5 sector zero
    run_req(1, 0, 0, 32'hFFFF_FFFF, 6, 0);             // R5 R6 all sectors
    run_req(0, {5'd4, 13'd0, 3'd6}, 8'h81, 0, 10, 1);  // R1 stray request
    l = 0;
    repeat (50) begin
      @(negedge clk);
      chk(req_ready && fl_we_n && fl_ce_n, "R1", "no activity after stray", wr_n, 4);
    end

    for (int k = 0; k < 16; k++) begin
      op = $urandom % 3;
      s = $urandom % 32; o = $urandom % 8;
      a = {s[4:0], 13'd0, o[2:0]};
      cur = mem[s*8+o];
      d = (($urandom % 4) != 0) ? (cur & 8'($urandom)) : 8'($urandom);
      m = ($urandom % 5 == 0) ? 32'h0 : ($urandom & $urandom);
      l = $urandom % 40;
      run_req(op, a, d, m, l, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule